// File: doc/BRIEF.md
# 2D Tile Load Layout Sequencer

This block turns the description of a 2D tile load into an ordered stream of register-file slots. For every element offset of the destination register file, starting at zero and counting up by one per accepted beat, it says either which byte address of a pitched surface must be read into that slot, or that the slot is padding and must be written with zero. A downstream memory reader consumes the stream; the reads themselves and any clipping against the surface edges happen elsewhere.

One command describes up to several tiles laid side by side along X. The tile width, tile height and tile count arrive minus one; the origin (X, Y) arrives as is. Four layouts are supported: row-major, row-major with vertical packing of small elements into 32-bit groups, transposed, and transposed with horizontal packing. Every register row is padded to a power of two, and every tile to a whole number of registers. The padding slots appear in the stream explicitly.

A command is taken by a one-cycle `start` pulse while the block is idle. The command pins are captured on that edge and may change afterwards. A command that cannot be laid out raises `err` for one cycle and produces no stream.

Top module: `lb2d_seq`

## Requirements
- R1: After reset, `busy`, `out_valid` and `err` are 0.
- R2: A command produces exactly B x block_pitch beats, with `out_offset` running 0, 1, 2, ... and one step per cycle with `out_valid` and `out_ready` both high. `out_last` is 1 only on the final beat. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R3: Element bytes are elem_sz = 1 << `elem_sz_code` (codes 0, 1 and 2 mean 1, 2 and 4 bytes). The source of the element at tile b, row y, column x is `surf_base + (org_y + y) * surf_pitch + (org_x + b*W + x) * elem_sz`, with W = `width_m1` + 1.
- R4: Row-major mode (`transpose`=0, `pack`=0): row y of tile b starts at offset b*block_pitch + y*row_pitch and holds columns 0..W-1 in order. row_pitch is W rounded up to a power of two.
- R5: Packed mode (`transpose`=0, `pack`=1), with group g = 4 / elem_sz: for each group of g rows starting at y and each column x, the g elements of rows y..y+g-1 sit at offsets y*row_pitch + x*g + 0..g-1.
- R6: Transposed mode (`transpose`=1, `pack`=0): column x of H elements (H = `height_m1` + 1) sits at offset x*row_pitch, in row order. row_pitch is H rounded up to a power of two.
- R7: Transposed packed mode (`transpose`=1, `pack`=1): for each group of g columns starting at x and each row y, the g elements of columns x..x+g-1 sit at offsets x*row_pitch + y*g + 0..g-1.
- R8: Every slot in a row past the row length (W, or H when transposed, times g when packed) up to the padded row end is a zero slot: `out_zero`=1 and `out_addr`=0.
- R9: block_size is row_pitch x H, or row_pitch x W when transposed. block_pitch is block_size rounded up to a multiple of 2^`reg_log2`. Offsets from block_size to block_pitch-1 of every tile are zero slots.
- R10: If `elem_sz_code` is 3, or `reg_log2` exceeds 10, or `pack`=1 and W or H is not a multiple of g, then `start` makes `err` 1 for exactly the next cycle. No beat is produced and `busy` stays 0.
- R11: A `start` pulse while `busy` is 1 is ignored, and a change on the command pins after the accepting edge does not alter the stream.
- R12: An accepted `start` makes `busy` and `out_valid` 1 in the cycle after the edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command pulse, taken while idle |
| elem_sz_code | input | 2 | Element size code: 0 means 1 B, 1 means 2 B, 2 means 4 B |
| blocks_m1 | input | BLK_W | Tile count minus one |
| width_m1 | input | DIM_W | Tile width in elements minus one |
| height_m1 | input | DIM_W | Tile height in elements minus one |
| org_x | input | COORD_W | Tile origin X in elements |
| org_y | input | COORD_W | Tile origin Y in rows |
| surf_base | input | ADDR_W | Surface base byte address |
| surf_pitch | input | PITCH_W | Surface row pitch in bytes |
| transpose | input | 1 | Transposed layout |
| pack | input | 1 | Pack small elements into 32-bit groups |
| reg_log2 | input | 4 | log2 of the register size in elements |
| out_ready | input | 1 | Consumer accepts the current beat |
| busy | output | 1 | A command is being streamed |
| err | output | 1 | One-cycle pulse: command rejected |
| out_valid | output | 1 | Beat present |
| out_offset | output | OFF_W | Register-file element offset |
| out_addr | output | ADDR_W | Source byte address, 0 for zero slots |
| out_zero | output | 1 | Slot is padding, write zero |
| out_last | output | 1 | Final beat of the command |

## Verification
The capture of a command takes one register stage. `out_valid` and the first beat, or the `err` pulse, are therefore due in the cycle right after the `start` edge, and the bench checks them at the next falling edge. After that, each beat depends only on the walk counters. The bench drives `out_ready` at a falling edge and samples the outputs shortly after. The beat it sees is the one the coming rising edge transfers, and the bench compares it with the next entry of a slot table that it builds behaviourally from R3 to R9. The table is compared on every cycle that a handshake completes. Stalled cycles must show the same offset again, so a beat that moves without a handshake is caught as an offset mismatch.

// File: rtl/lb2d_pkg.sv
// Shared types and helpers for the 2D tile layout sequencer.
// Assumes all internal geometry fits in 16 bits (tile sides up to 128).
package lb2d_pkg;

    // Element size codes as seen on the command pins
    typedef enum logic [1:0] {
        ESZ_1B  = 2'd0,
        ESZ_2B  = 2'd1,
        ESZ_4B  = 2'd2,
        ESZ_BAD = 2'd3
    } lb2d_esz_e;

    // Derived layout of one command, held for the whole walk
    typedef struct packed {
        logic [15:0] row_len;    // real elements per register row
        logic [15:0] row_pitch;  // row_len rounded up to a power of two
        logic [15:0] outer_cnt;  // register rows (or row groups) per tile
        logic [15:0] pad_cnt;    // tile padding slots up to the block pitch
        logic [1:0]  grp_m1;     // packing group size minus one
        logic [1:0]  grp_log2;   // log2 of the packing group size
        logic        xposed;     // transposed layout
    } lb2d_geom_t;

    // Smallest power of two not below n (n >= 1)
    function automatic logic [15:0] pow2_ceil(input logic [15:0] n);
        logic [15:0] r;
        r = 16'd1;
        for (int i = 0; i < 15; i++) begin
            if (r < n) r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/lb2d_geom.sv
// Layout geometry: derives row pitch, rows per tile, padding and the
// packing group from a raw command, and flags commands that cannot be
// laid out. Purely combinational; assumes DIM_W <= 7.
module lb2d_geom
    import lb2d_pkg::*;
#(
    parameter int DIM_W        = 6,
    parameter int MAX_REG_LOG2 = 10
) (
    input  logic [1:0]       elem_sz_code,
    input  logic [DIM_W-1:0] width_m1,
    input  logic [DIM_W-1:0] height_m1,
    input  logic             transpose,
    input  logic             pack,
    input  logic [3:0]       reg_log2,
    output lb2d_geom_t       geom,
    output logic             cfg_bad
);

    logic [15:0] wid, hgt, other_len, blk_size, reg_mask, blk_pitch;
    logic [1:0]  g_m1, g_log2;
    logic        misaligned;

    // Real sizes, packing group and geometry
    always_comb begin
        wid       = 16'(width_m1) + 16'd1;
        hgt       = 16'(height_m1) + 16'd1;
        g_m1      = pack ? (2'b11 >> elem_sz_code) : 2'b00;
        g_log2    = pack ? (2'd2 - ((elem_sz_code > 2'd2) ? 2'd2 : elem_sz_code)) : 2'd0;
        other_len = transpose ? wid : hgt;
        geom.row_len   = transpose ? hgt : wid;
        geom.row_pitch = pow2_ceil(geom.row_len);
        geom.outer_cnt = other_len >> g_log2;
        geom.grp_m1    = g_m1;
        geom.grp_log2  = g_log2;
        geom.xposed    = transpose;
        blk_size  = geom.row_pitch * other_len;
        reg_mask  = (16'd1 << reg_log2) - 16'd1;
        blk_pitch = (blk_size + reg_mask) & ~reg_mask;
        geom.pad_cnt = blk_pitch - blk_size;
    end

    // Command legality check
    always_comb begin
        misaligned = pack && (((wid & 16'(g_m1)) != 16'd0) || ((hgt & 16'(g_m1)) != 16'd0));
        cfg_bad    = (elem_sz_code == ESZ_BAD) || misaligned ||
                     (32'(reg_log2) > MAX_REG_LOG2);
    end

endmodule

// File: rtl/lb2d_walk.sv
// Slot walker: steps through tiles, register rows, row slots and the
// packing minor index, then through the tile padding, one slot per
// accepted beat. Assumes geom and blocks_m1 stay fixed while active
// and that launch is only raised when not active.
module lb2d_walk
    import lb2d_pkg::*;
#(
    parameter int BLK_W = 2,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  lb2d_geom_t       geom,
    input  logic [BLK_W-1:0] blocks_m1,
    input  logic             ready,
    output logic             active,
    output logic             last,
    output logic             zero,
    output logic [OFF_W-1:0] offset,
    output logic [BLK_W-1:0] blk,
    output logic [15:0]      elem_y,
    output logic [15:0]      elem_x
);

    logic             in_pad;
    logic [15:0]      r_cnt, m_cnt, p_cnt, line;
    logic [1:0]       k_cnt;
    logic             elem_end, blk_end, final_blk;

    // End-of-tile and end-of-command detection
    always_comb begin
        elem_end  = (k_cnt == geom.grp_m1) && (m_cnt == geom.row_pitch - 16'd1) &&
                    (r_cnt == geom.outer_cnt - 16'd1);
        blk_end   = in_pad ? (p_cnt == geom.pad_cnt - 16'd1)
                           : (elem_end && (geom.pad_cnt == 16'd0));
        final_blk = (blk == blocks_m1);
        last      = active && blk_end && final_blk;
    end

    // Element coordinates of the current slot and zero marking
    always_comb begin
        line   = (r_cnt << geom.grp_log2) | 16'(k_cnt);
        elem_y = geom.xposed ? m_cnt : line;
        elem_x = geom.xposed ? line : m_cnt;
        zero   = in_pad || (m_cnt >= geom.row_len);
    end

    // Counter walk, one slot per handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            in_pad <= 1'b0;
            blk    <= '0;
            r_cnt  <= '0;
            m_cnt  <= '0;
            k_cnt  <= '0;
            p_cnt  <= '0;
            offset <= '0;
        end else if (launch) begin
            active <= 1'b1;
            in_pad <= 1'b0;
            blk    <= '0;
            r_cnt  <= '0;
            m_cnt  <= '0;
            k_cnt  <= '0;
            p_cnt  <= '0;
            offset <= '0;
        end else if (active && ready) begin
            offset <= offset + 1'b1;
            if (in_pad) begin
                if (p_cnt == geom.pad_cnt - 16'd1) begin
                    p_cnt  <= '0;
                    in_pad <= 1'b0;
                    if (final_blk) active <= 1'b0;
                    else           blk    <= blk + 1'b1;
                end else begin
                    p_cnt <= p_cnt + 16'd1;
                end
            end else if (k_cnt == geom.grp_m1) begin
                k_cnt <= '0;
                if (m_cnt == geom.row_pitch - 16'd1) begin
                    m_cnt <= '0;
                    if (r_cnt == geom.outer_cnt - 16'd1) begin
                        r_cnt <= '0;
                        if (geom.pad_cnt != 16'd0) in_pad <= 1'b1;
                        else if (final_blk)        active <= 1'b0;
                        else                       blk    <= blk + 1'b1;
                    end else begin
                        r_cnt <= r_cnt + 16'd1;
                    end
                end else begin
                    m_cnt <= m_cnt + 16'd1;
                end
            end else begin
                k_cnt <= k_cnt + 2'd1;
            end
        end
    end

    AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ready && !last && !launch) |=> (offset == $past(offset) + 1'b1)); // R2
    AST_FIRST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (offset == '0)); // R2
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ready && last) |=> !active); // R2

endmodule

// File: rtl/lb2d_addr.sv
// Source address generator: turns tile index and element coordinates
// into a surface byte address; zero slots give address 0.
// Assumes the sum wraps modulo 2^ADDR_W.
module lb2d_addr #(
    parameter int ADDR_W  = 32,
    parameter int BLK_W   = 2,
    parameter int COORD_W = 16,
    parameter int PITCH_W = 24
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    input  logic [15:0]        tile_w,
    input  logic [1:0]         esz_log2,
    input  logic [BLK_W-1:0]   blk,
    input  logic [15:0]        elem_y,
    input  logic [15:0]        elem_x,
    input  logic               zero,
    output logic [ADDR_W-1:0]  addr
);

    logic [ADDR_W-1:0] row_a, col_a, row_off;

    // Row byte offset plus column byte offset
    always_comb begin
        row_a   = ADDR_W'(org_y) + ADDR_W'(elem_y);
        col_a   = ADDR_W'(org_x) + ADDR_W'(blk) * ADDR_W'(tile_w) + ADDR_W'(elem_x);
        row_off = row_a * ADDR_W'(pitch);
        addr    = zero ? '0 : (base + row_off + (col_a << esz_log2));
    end

endmodule

// File: rtl/lb2d_seq.sv
// Top of the 2D tile layout sequencer: captures a command on start,
// rejects illegal ones with a one-cycle error, and streams one
// register-file slot per handshake. Assumes start is ignored while busy.
module lb2d_seq
    import lb2d_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int DIM_W        = 6,
    parameter int BLK_W        = 2,
    parameter int COORD_W      = 16,
    parameter int PITCH_W      = 24,
    parameter int OFF_W        = 16,
    parameter int MAX_REG_LOG2 = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         elem_sz_code,
    input  logic [BLK_W-1:0]   blocks_m1,
    input  logic [DIM_W-1:0]   width_m1,
    input  logic [DIM_W-1:0]   height_m1,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    input  logic [ADDR_W-1:0]  surf_base,
    input  logic [PITCH_W-1:0] surf_pitch,
    input  logic               transpose,
    input  logic               pack,
    input  logic [3:0]         reg_log2,
    input  logic               out_ready,
    output logic               busy,
    output logic               err,
    output logic               out_valid,
    output logic [OFF_W-1:0]   out_offset,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_zero,
    output logic               out_last
);

    lb2d_geom_t         geom_d, geom_q;
    logic               cfg_bad, accept, launch;
    logic [BLK_W-1:0]   blocks_q, blk;
    logic [COORD_W-1:0] ox_q, oy_q;
    logic [ADDR_W-1:0]  base_q;
    logic [PITCH_W-1:0] pitch_q;
    logic [15:0]        tile_w_q, elem_y, elem_x;
    logic [1:0]         esz_q;

    lb2d_geom #(
        .DIM_W        (DIM_W),
        .MAX_REG_LOG2 (MAX_REG_LOG2)
    ) u_geom (
        .elem_sz_code (elem_sz_code),
        .width_m1     (width_m1),
        .height_m1    (height_m1),
        .transpose    (transpose),
        .pack         (pack),
        .reg_log2     (reg_log2),
        .geom         (geom_d),
        .cfg_bad      (cfg_bad)
    );

    // Command acceptance
    always_comb begin
        accept = start && !busy;
        launch = accept && !cfg_bad;
    end

    // Command capture and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err      <= 1'b0;
            geom_q   <= '0;
            blocks_q <= '0;
            ox_q     <= '0;
            oy_q     <= '0;
            base_q   <= '0;
            pitch_q  <= '0;
            tile_w_q <= '0;
            esz_q    <= '0;
        end else begin
            err <= accept && cfg_bad;
            if (launch) begin
                geom_q   <= geom_d;
                blocks_q <= blocks_m1;
                ox_q     <= org_x;
                oy_q     <= org_y;
                base_q   <= surf_base;
                pitch_q  <= surf_pitch;
                tile_w_q <= 16'(width_m1) + 16'd1;
                esz_q    <= elem_sz_code;
            end
        end
    end

    lb2d_walk #(
        .BLK_W (BLK_W),
        .OFF_W (OFF_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .geom      (geom_q),
        .blocks_m1 (blocks_q),
        .ready     (out_ready),
        .active    (busy),
        .last      (out_last),
        .zero      (out_zero),
        .offset    (out_offset),
        .blk       (blk),
        .elem_y    (elem_y),
        .elem_x    (elem_x)
    );

    lb2d_addr #(
        .ADDR_W  (ADDR_W),
        .BLK_W   (BLK_W),
        .COORD_W (COORD_W),
        .PITCH_W (PITCH_W)
    ) u_addr (
        .base     (base_q),
        .pitch    (pitch_q),
        .org_x    (ox_q),
        .org_y    (oy_q),
        .tile_w   (tile_w_q),
        .esz_log2 (esz_q),
        .blk      (blk),
        .elem_y   (elem_y),
        .elem_x   (elem_x),
        .zero     (out_zero),
        .addr     (out_addr)
    );

    // The stream is valid for the whole walk
    always_comb out_valid = busy;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_offset) &&
        $stable(out_addr) && $stable(out_zero) && $stable(out_last))); // R2
    AST_START_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !cfg_bad) |=> out_valid); // R12
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R10
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!out_valid && !busy)); // R10

endmodule

// File: tb/lb2d_seq_tb.sv
module lb2d_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  elem_sz_code = '0;
    logic [1:0]  blocks_m1 = '0;
    logic [5:0]  width_m1 = '0, height_m1 = '0;
    logic [15:0] org_x = '0, org_y = '0;
    logic [31:0] surf_base = '0;
    logic [23:0] surf_pitch = '0;
    logic        transpose = 1'b0, pack = 1'b0;
    logic [3:0]  reg_log2 = '0;
    logic        out_ready = 1'b0;
    logic        busy, err, out_valid, out_zero, out_last;
    logic [15:0] out_offset;
    logic [31:0] out_addr;

    int tests = 0;
    int fails = 0;
    int exp_addr[];
    bit exp_zero[];

    always #4 clk = ~clk;   // 125 MHz

    lb2d_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .elem_sz_code(elem_sz_code),
        .blocks_m1(blocks_m1), .width_m1(width_m1), .height_m1(height_m1),
        .org_x(org_x), .org_y(org_y), .surf_base(surf_base), .surf_pitch(surf_pitch),
        .transpose(transpose), .pack(pack), .reg_log2(reg_log2), .out_ready(out_ready),
        .busy(busy), .err(err), .out_valid(out_valid), .out_offset(out_offset),
        .out_addr(out_addr), .out_zero(out_zero), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference slot table built from the layout rules (R3..R9)
    task automatic build_ref(input int esc, input int bm1, input int wm1, input int hm1,
                             input int ox, input int oy, input longint base, input longint pit,
                             input bit tr, input bit pk, input int rlog, output int total);
        int eb = 1 << esc;
        int nb = bm1 + 1, w = wm1 + 1, h = hm1 + 1;
        int g = pk ? 4 / eb : 1;
        int rl = tr ? h : w;
        int rp = 1;
        int bs, bp, rs;
        while (rp < rl) rp = rp * 2;
        bs = rp * (tr ? w : h);
        rs = 1 << rlog;
        bp = ((bs + rs - 1) / rs) * rs;
        total = nb * bp;
        exp_addr = new[total];
        exp_zero = new[total];
        for (int i = 0; i < total; i++) begin exp_addr[i] = 0; exp_zero[i] = 1; end
        for (int b = 0; b < nb; b++) begin
            if (!tr && !pk) begin
                for (int y = 0; y < h; y++)
                    for (int x = 0; x < w; x++)
                        put_slot(b*bp + y*rp + x, b, y, x, eb, w, ox, oy, base, pit);
            end else if (!tr && pk) begin
                for (int y = 0; y < h; y += g)
                    for (int x = 0; x < w; x++)
                        for (int i = 0; i < g; i++)
                            put_slot(b*bp + y*rp + x*g + i, b, y + i, x, eb, w, ox, oy, base, pit);
            end else if (tr && !pk) begin
                for (int x = 0; x < w; x++)
                    for (int y = 0; y < h; y++)
                        put_slot(b*bp + x*rp + y, b, y, x, eb, w, ox, oy, base, pit);
            end else begin
                for (int x = 0; x < w; x += g)
                    for (int y = 0; y < h; y++)
                        for (int i = 0; i < g; i++)
                            put_slot(b*bp + x*rp + y*g + i, b, y, x + i, eb, w, ox, oy, base, pit);
            end
        end
    endtask

    task automatic put_slot(input int off, input int b, input int y, input int x,
                            input int eb, input int w, input int ox, input int oy,
                            input longint base, input longint pit);
        longint a = base + longint'(oy + y) * pit + longint'(ox + b*w + x) * eb;
        exp_addr[off] = int'(a & 64'hFFFF_FFFF);
        exp_zero[off] = 0;
    endtask

    // Issue one legal command and compare the whole stream; ready pattern per stall
    task automatic run_cmd(input string req, input int esc, input int bm1, input int wm1,
                           input int hm1, input int ox, input int oy, input longint base,
                           input longint pit, input bit tr, input bit pk, input int rlog,
                           input int stall, input bit poke);
        int total, idx, cyc;
        bit done;
        build_ref(esc, bm1, wm1, hm1, ox, oy, base, pit, tr, pk, rlog, total);
        @(negedge clk);
        elem_sz_code = 2'(esc); blocks_m1 = 2'(bm1); width_m1 = 6'(wm1); height_m1 = 6'(hm1);
        org_x = 16'(ox); org_y = 16'(oy); surf_base = 32'(base); surf_pitch = 24'(pit);
        transpose = tr; pack = pk; reg_log2 = 4'(rlog); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11: command pins scrambled after capture
        width_m1 = ~width_m1; height_m1 = ~height_m1; org_x = ~org_x; surf_base = ~surf_base;
        transpose = ~transpose; elem_sz_code = 2'd1;
        check(out_valid === 1'b1 && busy === 1'b1, "R12", "valid after start", out_valid, 1);
        idx = 0; cyc = 0; done = 0;
        while (!done && cyc < 20000) begin
            out_ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 1);
            // R11: a start pulse while busy must be ignored
            start = poke && (cyc == 7);
            #1;
            if (out_ready && out_valid) begin
                check(out_offset == 16'(idx), "R2", "offset", out_offset, idx);
                check(out_zero == exp_zero[idx], exp_zero[idx] ? "R8/R9" : "R4-R7", "zero flag",
                      out_zero, exp_zero[idx]);
                check(out_addr == 32'(exp_addr[idx]), "R3", "address", out_addr, exp_addr[idx]);
                check(out_last == (idx == total - 1), "R2", "last flag", out_last, idx == total - 1);
                if (idx == total - 1) done = 1;
                idx++;
            end else if (!out_valid) begin
                check(0, req, "valid dropped early at beat", idx, total);
                done = 1;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(done, req, "stream completed", idx, total);
        check(out_valid === 1'b0 && busy === 1'b0, "R2", "idle after last", out_valid, 0);
        out_ready = 1'b0;
    endtask

    // Issue one illegal command and check the error pulse (R10)
    task automatic run_bad(input int esc, input int wm1, input int hm1, input bit pk, input int rlog);
        @(negedge clk);
        elem_sz_code = 2'(esc); width_m1 = 6'(wm1); height_m1 = 6'(hm1);
        pack = pk; transpose = 1'b0; reg_log2 = 4'(rlog); blocks_m1 = '0; start = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err === 1'b1, "R10", "err pulse", err, 1);
        check(out_valid === 1'b0 && busy === 1'b0, "R10", "no stream on error", out_valid, 0);
        @(negedge clk);
        check(err === 1'b0, "R10", "err single cycle", err, 0);
        check(out_valid === 1'b0, "R10", "still no stream", out_valid, 0);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0 && out_valid === 1'b0 && err === 1'b0, "R1", "reset outputs",
              {busy, out_valid, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && out_valid === 1'b0, "R1", "idle after reset", busy, 0);
        // R4 row-major 4B, two tiles, tile padding (R9)
        run_cmd("R4", 2, 1, 3, 2, 5, 2, 32'h1000, 64, 0, 0, 3, 0, 0);
        // R4/R8 row-major 1B, row tail padding, stalls
        run_cmd("R8", 0, 0, 4, 1, 1, 0, 32'h2000, 40, 0, 0, 4, 3, 0);
        // R5 packed 2B with row tail
        run_cmd("R5", 1, 0, 5, 3, 2, 1, 32'h3000, 100, 0, 1, 3, 0, 0);
        // R5 packed 1B with tile padding (R9), stalls and ignored start (R11)
        run_cmd("R5", 0, 1, 3, 7, 0, 3, 32'h4000, 16, 0, 1, 6, 2, 1);
        // R6 transposed 4B, two tiles, no tile padding
        run_cmd("R6", 2, 1, 2, 4, 3, 1, 32'h5000, 256, 1, 0, 3, 0, 0);
        // R7 transposed packed 2B
        run_cmd("R7", 1, 2, 3, 5, 0, 0, 32'h6000, 80, 1, 1, 5, 4, 1);
        // R10 illegal commands
        run_bad(0, 3, 5, 1, 3);
        run_bad(3, 1, 1, 0, 3);
        run_bad(2, 1, 1, 0, 12);
        // R12 again after errors: normal command still accepted
        run_cmd("R12", 2, 0, 0, 0, 9, 9, 32'h7000, 12, 0, 0, 0, 0, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule